// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block generates four independent pulse-width modulated outputs from one input clock. Software configures it through a small word-addressed register bus: each channel has a control word (run bit and clock divider), a high-time word and a cycle-length word. A single global enable word sits above all channels. A channel produces pulses only when both its own run bit and the global enable are set.

Each channel divides the input clock by (divider + 1). It then counts the divided ticks through one output cycle of the programmed length. The output is high while the tick count is below the programmed high time. New settings written while a channel runs are held back until the current output cycle ends, so no pulse is cut short. Stopping a channel, or clearing the global enable, drives the output low and returns the channel's counters to zero. When the channel starts again its waveform restarts from the beginning of a cycle.

Top module: `pwm_quad`

## Requirements
- R1: Register readback: channel n (0..3) occupies byte offsets 16n (control), 16n+4 (high time), 16n+8 (cycle length), and the global enable sits at 0x3C. The control word reads back bit 0 (run) and bits 15:2 (divider, 0..0x3FFF), so 0xFFFFFFFF reads 0x0000FFFD. The high-time and cycle-length words read back bits 15:0. The global word reads back bit 0 only. All other bits read zero.
- R2: An address that is not word-aligned (bits 1:0 not zero) or that falls on channel offset 0xC (0x0C, 0x1C, 0x2C) reads zero, and a write to it changes no register.
- R3: After the synchronous active-low reset, every register reads zero and every output is low.
- R4: With global enable set, cycle length P > 0, high time D and divider S, the output in the k-th clock after the run-bit write edge (k = 0 first) is high exactly when floor(k/(S+1)) mod P < D. One cycle therefore lasts (S+1)·P clocks, and the high time is (S+1)·D clocks.
- R5: While the global enable is clear, every output is low. Setting it starts every channel whose run bit is set from k = 0 at the same edge.
- R6: A channel whose run bit is clear holds its output low. Setting the run bit again restarts the waveform from k = 0.
- R7: A change to the high time, cycle length or divider written while a channel runs takes effect only at the next cycle boundary.
- R8: High time greater than or equal to the cycle length gives a constant high output. A cycle length of zero, or a high time of zero, gives a constant low output.
- R9: Channels run independently. Two channels started together each follow R4 with their own settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock, also the count clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (6) | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one write per clock |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | NCH (4) | Active-high PWM outputs, one bit per channel |

## Verification
A wrong divider or cycle count shows up as an output edge out of place at the first cycle boundary after the channel starts. That is within (S+1)·P clocks, and each waveform check compares every clock against the R4 formula. A shadow register that loads at the wrong time appears as a changed high time inside the cycle that was running during the write. A counter that survives a stop shows as a phase offset in the first clocks after a restart. Decode faults show at once on readback or as writes that land in the wrong register.

// File: rtl/pwm_quad_pkg.sv
// Shared widths, offsets and the per-channel configuration record.
// Assumes 32-bit bus words and a byte-addressed map with 16-byte channel stride.
package pwm_quad_pkg;
    localparam int DIV_W      = 14;   // clock divider field width
    localparam int CNT_W      = 16;   // high-time / cycle-length width
    localparam int DIV_LSB    = 2;    // divider field position in control word
    localparam int GLOBAL_OFS = 'h3C; // global enable word
    localparam int STRIDE_LSB = 4;    // 16-byte channel stride

    typedef struct packed {
        logic             run;
        logic [DIV_W-1:0] div;
        logic [CNT_W-1:0] high;
        logic [CNT_W-1:0] len;
    } ch_cfg_t;
endpackage

// File: rtl/pwm_regfile.sv
// Register file: decodes the word bus, holds the global enable and per-channel
// settings, and returns readback data combinationally.
// Assumes NCH*16 <= 2**ADDR_W and that the global word does not alias a live channel register.
module pwm_regfile
    import pwm_quad_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              global_en,
    output ch_cfg_t           cfg [NCH]
);
    localparam int SEL_W = ADDR_W - STRIDE_LSB;

    logic             aligned;
    logic [1:0]       word_ofs;
    logic [SEL_W-1:0] ch_sel;
    logic             global_hit;
    logic [NCH-1:0]   ch_hit;
    logic             unused_wdata;

    assign aligned    = (bus_addr[1:0] == 2'b00);
    assign word_ofs   = bus_addr[3:2];
    assign ch_sel     = bus_addr[ADDR_W-1:STRIDE_LSB];
    assign global_hit = aligned && (bus_addr == ADDR_W'(GLOBAL_OFS));
    assign unused_wdata = ^{bus_wdata[31:16], bus_wdata[1]};

    // Global enable register update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            global_en <= 1'b0;
        else if (bus_we && global_hit)
            global_en <= bus_wdata[0];
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign ch_hit[g] = aligned && (int'(ch_sel) == g) && (word_ofs != 2'd3);

        // Per-channel settings update.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg[g] <= '0;
            end else if (bus_we && ch_hit[g]) begin
                case (word_ofs)
                    2'd0: begin
                        cfg[g].run <= bus_wdata[0];
                        cfg[g].div <= bus_wdata[DIV_LSB +: DIV_W];
                    end
                    2'd1:    cfg[g].high <= bus_wdata[CNT_W-1:0];
                    2'd2:    cfg[g].len  <= bus_wdata[CNT_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    // Readback mux; unmapped and misaligned addresses return zero.
    always_comb begin
        bus_rdata = '0;
        if (global_hit)
            bus_rdata[0] = global_en;
        for (int i = 0; i < NCH; i++) begin
            if (ch_hit[i]) begin
                case (word_ofs)
                    2'd0:    bus_rdata = {16'b0, cfg[i].div, 1'b0, cfg[i].run};
                    2'd1:    bus_rdata = {16'b0, cfg[i].high};
                    2'd2:    bus_rdata = {16'b0, cfg[i].len};
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/pwm_prescaler.sv
// Clock divider: emits one tick every (div+1) clocks while run is high.
// Assumes the caller holds div steady between ticks; clears when run drops.
module pwm_prescaler #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] div,
    output logic         tick,
    output logic [W-1:0] phase
);
    assign tick = run && (phase == div);

    // Divider phase counter, restarting at each tick or when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end
endmodule

// File: rtl/pwm_channel.sv
// One PWM channel: shadows its settings at cycle boundaries, counts divided
// ticks through a cycle and drives the output during the high portion.
// Assumes live settings come from the register file; on the first running
// clock the live values are used directly so a start write takes effect at once.
module pwm_channel
    import pwm_quad_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  ch_cfg_t          live,
    output logic             pwm,
    output logic [CNT_W-1:0] cyc_cnt,
    output logic [DIV_W-1:0] div_phase
);
    logic             run_q;
    logic             start;
    logic             tick;
    logic             boundary;
    logic [DIV_W-1:0] div_s,  div_e;
    logic [CNT_W-1:0] high_s, high_e;
    logic [CNT_W-1:0] len_s,  len_e;

    assign start  = run && !run_q;
    assign div_e  = start ? live.div  : div_s;
    assign high_e = start ? live.high : high_s;
    assign len_e  = start ? live.len  : len_s;

    assign boundary = (len_e == '0) ||
                      ({1'b0, cyc_cnt} + (CNT_W+1)'(1) >= {1'b0, len_e});

    pwm_prescaler #(.W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (div_e),
        .tick  (tick),
        .phase (div_phase)
    );

    // Cycle counter and shadow settings, reloaded at each cycle boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            cyc_cnt <= '0;
            div_s   <= '0;
            high_s  <= '0;
            len_s   <= '0;
        end else begin
            run_q <= run;
            if (!run || start || (tick && boundary)) begin
                div_s  <= live.div;
                high_s <= live.high;
                len_s  <= live.len;
            end
            if (!run)
                cyc_cnt <= '0;
            else if (tick)
                cyc_cnt <= boundary ? '0 : cyc_cnt + 1'b1;
        end
    end

    assign pwm = run && (len_e != '0) && (cyc_cnt < high_e);
endmodule

// File: rtl/pwm_quad.sv
// Top level: register file plus NCH PWM channels gated by the global enable.
// Assumes a single clock domain; the count clock is the bus clock.
module pwm_quad
    import pwm_quad_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NCH-1:0]    pwm_out
);
    logic                   global_en;
    ch_cfg_t                cfg [NCH];
    logic [NCH-1:0]         run_vec;
    logic [NCH*CNT_W-1:0]   cyc_flat;
    logic [NCH*DIV_W-1:0]   phase_flat;

    pwm_regfile #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .global_en (global_en),
        .cfg       (cfg)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign run_vec[g] = global_en && cfg[g].run;

        pwm_channel u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (run_vec[g]),
            .live      (cfg[g]),
            .pwm       (pwm_out[g]),
            .cyc_cnt   (cyc_flat[g*CNT_W +: CNT_W]),
            .div_phase (phase_flat[g*DIV_W +: DIV_W])
        );
    end
endmodule

// File: rtl/pwm_quad_chk.sv
// Checker for pwm_quad: gating, readback of misaligned addresses, and that
// every rising output edge coincides with the start of a cycle.
module pwm_quad_chk
    import pwm_quad_pkg::*;
#(
    parameter int NCH = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           addr_lo,
    input logic [31:0]          bus_rdata,
    input logic [NCH-1:0]       pwm_out,
    input logic                 global_en,
    input logic [NCH-1:0]       run_vec,
    input logic [NCH*CNT_W-1:0] cyc_flat,
    input logic [NCH*DIV_W-1:0] phase_flat
);
    // R5: global enable clear forces every output low.
    a_r5_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !global_en |-> (pwm_out == '0));

    // R6: a stopped channel never drives high.
    a_r6_stopped_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwm_out & ~run_vec) == '0));

    // R2: misaligned reads return zero.
    a_r2_misaligned_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_lo != 2'b00) |-> (bus_rdata == '0));

    for (genvar g = 0; g < NCH; g++) begin : g_edge
        // R4: an output only rises at the first clock of a cycle.
        a_r4_rise_at_cycle_start: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pwm_out[g]) |-> ((cyc_flat[g*CNT_W +: CNT_W] == '0) &&
                                   (phase_flat[g*DIV_W +: DIV_W] == '0)));
    end
endmodule

bind pwm_quad pwm_quad_chk #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_lo    (bus_addr[1:0]),
    .bus_rdata  (bus_rdata),
    .pwm_out    (pwm_out),
    .global_en  (global_en),
    .run_vec    (run_vec),
    .cyc_flat   (cyc_flat),
    .phase_flat (phase_flat)
);

// File: tb/sim_pwm_quad.sv
module sim_pwm_quad;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  pwm_out;
    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk; // 50 MHz

    pwm_quad u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wdata), .bus_rdata(rdata), .pwm_out(pwm_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write lands at the next rising edge; returns at the following falling edge.
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; we = 1'b0;
        #1 d = rdata;
    endtask

    function automatic logic exp_bit(input int k, input int div, input int len, input int high);
        if (len == 0) return 1'b0;
        return ((k / (div + 1)) % len) < high;
    endfunction

    // Compares one channel with the R4 formula for n clocks from k = 0.
    task automatic wave(input int ch, input int div, input int len, input int high,
                        input int n, input string req);
        int bad = 0;
        for (int k = 0; k < n; k++) begin
            if (pwm_out[ch] !== exp_bit(k, div, len, high)) bad++;
            @(negedge clk);
        end
        chk(req, bad, 0);
    endtask

    task automatic low_for(input int n, input logic [3:0] mask, input string req);
        int bad = 0;
        for (int k = 0; k < n; k++) begin
            if ((pwm_out & mask) !== 4'b0) bad++;
            @(negedge clk);
        end
        chk(req, bad, 0);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R3 outputs low", {28'b0, pwm_out}, 32'h0);
        rd(6'h00, d); chk("R3 ctrl0", d, 0);
        rd(6'h04, d); chk("R3 high0", d, 0);
        rd(6'h38, d); chk("R3 len3", d, 0);
        rd(6'h3C, d); chk("R3 global", d, 0);
    endtask

    task automatic t_readback;
        logic [31:0] d;
        wr(6'h3C, 32'hFFFF_FFFF);
        rd(6'h3C, d); chk("R1 global bit0", d, 32'h1);
        wr(6'h14, 32'hFFFF_FFFF);
        rd(6'h14, d); chk("R1 high1 mask", d, 32'h0000_FFFF);
        wr(6'h28, 32'h1234_5678);
        rd(6'h28, d); chk("R1 len2 mask", d, 32'h0000_5678);
        wr(6'h10, 32'hFFFF_FFFF);
        rd(6'h10, d); chk("R1 ctrl1 mask", d, 32'h0000_FFFD);
        wr(6'h10, 32'h0);
        wr(6'h14, 32'h0);
        wr(6'h28, 32'h0);
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        wr(6'h04, 32'h0000_00AA);
        wr(6'h05, 32'h0000_5555);
        wr(6'h0C, 32'hFFFF_FFFF);
        wr(6'h1C, 32'hFFFF_FFFF);
        rd(6'h04, d); chk("R2 misaligned write ignored", d, 32'hAA);
        rd(6'h05, d); chk("R2 misaligned read zero", d, 0);
        rd(6'h0C, d); chk("R2 offset C reads zero", d, 0);
        rd(6'h1C, d); chk("R2 offset 1C reads zero", d, 0);
        rd(6'h00, d); chk("R2 ctrl0 untouched", d, 0);
        wr(6'h04, 32'h0);
    endtask

    task automatic t_basic;
        wr(6'h04, 2); wr(6'h08, 5);
        wr(6'h00, (0 << 2) | 1);
        wave(0, 0, 5, 2, 40, "R4 div0 len5 high2");
        wr(6'h00, 0);
        wr(6'h04, 1); wr(6'h08, 4);
        wr(6'h00, (2 << 2) | 1);
        wave(0, 2, 4, 1, 48, "R4 div2 len4 high1");
        wr(6'h00, 0);
    endtask

    task automatic t_extremes;
        wr(6'h24, 7); wr(6'h28, 3);
        wr(6'h20, 1);
        wave(2, 0, 3, 7, 20, "R8 high>=len constant high");
        chk("R8 high output", {31'b0, pwm_out[2]}, 32'h1);
        wr(6'h20, 0);
        wr(6'h24, 5); wr(6'h28, 0);
        wr(6'h20, 1);
        low_for(20, 4'b0100, "R8 zero length low");
        wr(6'h20, 0);
        wr(6'h24, 0); wr(6'h28, 4);
        wr(6'h20, (1 << 2) | 1);
        low_for(20, 4'b0100, "R8 zero high low");
        wr(6'h20, 0);
    endtask

    task automatic t_deferred;
        int bad = 0;
        wr(6'h14, 2); wr(6'h18, 8);
        wr(6'h10, 1);
        for (int k = 0; k < 24; k++) begin
            logic ex;
            ex = (k < 8) ? (k < 2) : (((k - 8) % 8) < 6);
            if (pwm_out[1] !== ex) bad++;
            if (k == 3) begin addr = 6'h14; wdata = 6; we = 1'b1; end
            if (k == 4) we = 1'b0;
            @(negedge clk);
        end
        chk("R7 high change deferred to boundary", bad, 0);
        wr(6'h10, 0);
    endtask

    task automatic t_restart;
        wr(6'h24, 1); wr(6'h28, 3);
        wr(6'h20, (1 << 2) | 1);
        repeat (3) @(negedge clk);
        wr(6'h20, (1 << 2) | 0);
        low_for(6, 4'b0100, "R6 stopped channel low");
        wr(6'h20, (1 << 2) | 1);
        wave(2, 1, 3, 1, 18, "R6 restart from cycle start");
        wr(6'h20, 0);
    endtask

    task automatic t_global;
        int bad = 0;
        wr(6'h3C, 0);
        wr(6'h04, 2); wr(6'h08, 5); wr(6'h00, 1);
        wr(6'h34, 3); wr(6'h38, 4); wr(6'h30, (2 << 2) | 1);
        low_for(10, 4'b1111, "R5 global clear holds low");
        wr(6'h3C, 1);
        for (int k = 0; k < 36; k++) begin
            if (pwm_out[0] !== exp_bit(k, 0, 5, 2)) bad++;
            if (pwm_out[3] !== exp_bit(k, 2, 4, 3)) bad++;
            @(negedge clk);
        end
        chk("R9 R5 two channels start together", bad, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_readback();
        t_unmapped();
        t_basic();
        t_extremes();
        t_deferred();
        t_restart();
        t_global();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule